// File: doc/BRIEF.md
# Transceiver Retune Handshake Sequencer

This block sits on the user side of a video receiver. The receiver detects a new video standard and asks for its serial transceiver to be retuned. The sequencer services that request. It captures the 2-bit standard code and lowers its done line to show that work is under way. It then streams a fixed sequence of 28 configuration words to the transceiver's reconfiguration port, each with a valid strobe. The words come from a small synchronous lookup that holds one region per standard.

After the last word, the sequencer waits for the channel to report that it has finished reconfiguring. It then raises done, which lets the receiver start locking to incoming data. The sequencer accepts no new request until the requester has dropped its request line, so the handshake is four-phase. The receiver's CRC error flag is expected to fire while the link is being retuned, so the block also provides a qualified copy of that flag, masked while done is low.

Top module: `xcvr_retune_seq`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block goes idle with `cfg_done`=1, `cfg_valid`=0 and `cfg_addr`=0.
- R2: When idle with `cfg_done`=1 and `start_req` sampled high at an edge, `cfg_done` is 0 after that edge.
- R3: One request produces exactly 28 `cfg_valid` beats on consecutive cycles. Their `cfg_addr` is `{std, idx}`: `std` in bits [6:5] and the word index in bits [4:0], with the index running 0 to 27 in increasing order.
- R4: The word on `cfg_data` during each valid beat equals `{std[1:0], idx[4:0], (idx*3+5) mod 512 as 9 bits}`, with `std` in the top two bits.
- R5: The standard is captured at the edge that accepts the request. Changes on `std_sel` after that edge have no effect on the addresses or data of that sequence.
- R6: `cfg_done` stays 0 until a `ch_done` pulse arrives after the last word has been issued. A `ch_done` pulse while words are still being sent is ignored.
- R7: Once all words are issued, `ch_done` sampled high at an edge makes `cfg_done` 1 after that edge.
- R8: While `start_req` stays high after `cfg_done` has risen, no new sequence starts and `cfg_done` stays 1. A new request is accepted only after `start_req` has been seen low.
- R9: `crc_err_q` equals `crc_err_raw` AND `cfg_done`, so a CRC error is masked while reconfiguration is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| std_sel | input | 2 | Requested video standard code |
| start_req | input | 1 | Reconfiguration request from the receiver |
| ch_done | input | 1 | Channel reconfiguration complete pulse |
| crc_err_raw | input | 1 | Raw CRC error flag from the receiver |
| cfg_done | output | 1 | High when no reconfiguration is in progress |
| cfg_valid | output | 1 | Strobe qualifying cfg_addr and cfg_data |
| cfg_addr | output | 7 | Lookup address {standard, word index} |
| cfg_data | output | 16 | Configuration word for the reconfiguration port |
| crc_err_q | output | 1 | CRC error qualified by cfg_done |

## Verification
The assertions assume that the requester follows the four-phase protocol. They also assume that `ch_done` is a pulse the channel may raise at any time, with only the one that follows the last word carrying meaning. The stimulus raises `start_req` only while done is high and holds it until done has risen. It toggles `std_sel` in mid-sequence and fires a stray `ch_done` during the word stream to probe the rules on ignored inputs. It keeps `crc_err_raw` high across a whole sequence so that the masking is seen at both levels of done.

// File: rtl/retune_pkg.sv
// Shared sizes and the sequencer state encoding.
// Assumes at most four standards and a sequence short enough for a 5-bit index.
package retune_pkg;
    localparam int STD_W  = 2;
    localparam int WORDS  = 28;
    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SEND,
        ST_WAIT_CH,
        ST_DONE_HI,
        ST_WAIT_LOW
    } seq_state_t;
endpackage

// File: rtl/retune_fsm.sv
// Handshake controller: accepts a request, captures the standard, issues
// WORDS read requests, waits for the channel, raises done and waits for
// the request to drop. Assumes ch_done is a single-cycle or longer pulse.
module retune_fsm
    import retune_pkg::*;
#(
    parameter int SW = STD_W,
    parameter int NW = WORDS,
    localparam int IW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] std_sel,
    input  logic          start_req,
    input  logic          ch_done,
    output logic          rd_en,
    output logic [SW-1:0] rd_std,
    output logic [IW-1:0] rd_idx,
    output logic          cfg_done
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NW - 1);

    seq_state_t    state;
    logic [SW-1:0] std_q;
    logic [IW-1:0] idx;

    // Read request is issued every cycle spent in the send state.
    always_comb begin
        rd_en  = (state == ST_SEND);
        rd_std = std_q;
        rd_idx = idx;
    end

    // State, captured standard, word index and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            std_q    <= '0;
            idx      <= '0;
            cfg_done <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: if (start_req) begin
                    state    <= ST_START;
                    std_q    <= std_sel;
                    cfg_done <= 1'b0;
                end
                ST_START: begin
                    state <= ST_SEND;
                    idx   <= '0;
                end
                ST_SEND: begin
                    if (idx == LAST_IDX) begin
                        state <= ST_WAIT_CH;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_WAIT_CH: if (ch_done) begin
                    state    <= ST_DONE_HI;
                    cfg_done <= 1'b1;
                end
                ST_DONE_HI: state <= ST_WAIT_LOW;
                ST_WAIT_LOW: if (!start_req) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: an accepted request lowers done on the next cycle.
    p_req_drops_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_req) |=> !cfg_done);

    // R3: the index never runs past the last word while reading.
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (idx <= LAST_IDX));

    // R5: the captured standard holds across consecutive reads.
    p_std_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> $stable(std_q));

    // R7: done rises only after a sampled channel-complete.
    p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(ch_done));

    // R8: a request still held high after completion does not retrigger.
    p_no_retrigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_LOW && start_req) |=> cfg_done);
endmodule

// File: rtl/retune_rom.sv
// Synchronous configuration lookup: registers the word, its address and
// the valid strobe one cycle after a read request. Contents are computed,
// one region per standard. Assumes DW >= SW + IW.
module retune_rom #(
    parameter int SW = 2,
    parameter int IW = 5,
    parameter int DW = 16,
    localparam int AW = SW + IW,
    localparam int LW = DW - SW - IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [SW-1:0] rd_std,
    input  logic [IW-1:0] rd_idx,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    logic [LW-1:0] low;

    // Low field of the word derived from the index.
    always_comb low = LW'(rd_idx) * LW'(3) + LW'(5);

    // Registered lookup output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            data  <= '0;
        end else begin
            valid <= rd_en;
            if (rd_en) begin
                addr <= {rd_std, rd_idx};
                data <= {rd_std, rd_idx, low};
            end
        end
    end

    // R4: every read request yields a valid word one cycle later.
    p_valid_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> valid);
endmodule

// File: rtl/xcvr_retune_seq.sv
// Top of the retune sequencer: joins the handshake controller to the
// configuration lookup and qualifies the receiver CRC error with done.
// Assumes the requester follows the four-phase request/done protocol.
module xcvr_retune_seq
    import retune_pkg::*;
#(
    parameter int SW = STD_W,
    parameter int NW = WORDS,
    parameter int DW = DATA_W,
    localparam int IW = $clog2(NW),
    localparam int AW = SW + IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] std_sel,
    input  logic          start_req,
    input  logic          ch_done,
    input  logic          crc_err_raw,
    output logic          cfg_done,
    output logic          cfg_valid,
    output logic [AW-1:0] cfg_addr,
    output logic [DW-1:0] cfg_data,
    output logic          crc_err_q
);
    logic          rd_en;
    logic [SW-1:0] rd_std;
    logic [IW-1:0] rd_idx;

    retune_fsm #(.SW(SW), .NW(NW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .std_sel  (std_sel),
        .start_req(start_req),
        .ch_done  (ch_done),
        .rd_en    (rd_en),
        .rd_std   (rd_std),
        .rd_idx   (rd_idx),
        .cfg_done (cfg_done)
    );

    retune_rom #(.SW(SW), .IW(IW), .DW(DW)) u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .rd_std(rd_std),
        .rd_idx(rd_idx),
        .valid (cfg_valid),
        .addr  (cfg_addr),
        .data  (cfg_data)
    );

    // CRC error is reported only when no reconfiguration is in progress.
    always_comb crc_err_q = crc_err_raw & cfg_done;

    // R9: no qualified CRC error while done is low.
    p_crc_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> !crc_err_q);

    // R6: words are never streamed while done is high.
    p_busy_when_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> !cfg_done);
endmodule

// File: tb/xcvr_retune_seq_tb.sv
module xcvr_retune_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  std_sel = '0;
    logic        start_req = 1'b0;
    logic        ch_done = 1'b0;
    logic        crc_err_raw = 1'b0;
    logic        cfg_done, cfg_valid, crc_err_q;
    logic [6:0]  cfg_addr;
    logic [15:0] cfg_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_retune_seq u_dut (
        .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .start_req(start_req),
        .ch_done(ch_done), .crc_err_raw(crc_err_raw), .cfg_done(cfg_done),
        .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .crc_err_q(crc_err_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [1:0] s, input int i);
        logic [8:0] lo;
        lo = 9'((i * 3 + 5) % 512);
        return {s, 5'(i), lo};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        crc_err_raw = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 done", cfg_done, 1);
        check("R1 valid", cfg_valid, 0);
        check("R1 addr", cfg_addr, 0);
        check("R9 crc at idle", crc_err_q, 1);
        crc_err_raw = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One full sequence; optional std change and stray ch_done mid-stream.
    task automatic t_sequence(input logic [1:0] s, input bit disturb);
        int cnt = 0;
        bit ord_ok = 1;
        bit data_ok = 1;
        std_sel = s;
        start_req = 1'b1;
        crc_err_raw = 1'b1;
        for (int cyc = 0; cyc < 40; cyc++) begin
            @(negedge clk);
            if (cyc == 0) begin
                check("R2 done low", cfg_done, 0);
                check("R9 crc masked", crc_err_q, 0);
            end
            if (cfg_valid) begin
                if (cfg_addr !== {s, 5'(cnt)}) begin
                    if (ord_ok) check("R3/R5 addr", cfg_addr, {s, 5'(cnt)});
                    ord_ok = 0;
                end
                if (cfg_data !== exp_word(s, cnt)) begin
                    if (data_ok) check("R4 data", cfg_data, exp_word(s, cnt));
                    data_ok = 0;
                end
                cnt++;
            end
            if (disturb) begin
                std_sel = ~s;
                ch_done = (cyc == 6);
            end
        end
        ch_done = 1'b0;
        if (ord_ok) check("R3 order", 1, 1);
        if (data_ok) check("R4 words", 1, 1);
        check("R3 beat count", cnt, 28);
        check("R6 done held low", cfg_done, 0);
        @(negedge clk);
        check("R6 still low", cfg_done, 0);
        ch_done = 1'b1;
        @(negedge clk);
        ch_done = 1'b0;
        check("R7 done rises", cfg_done, 1);
        check("R9 crc passes", crc_err_q, 1);
        cnt = 0;
        repeat (6) begin
            @(negedge clk);
            if (cfg_valid || !cfg_done) cnt++;
        end
        check("R8 no retrigger", cnt, 0);
        start_req = 1'b0;
        crc_err_raw = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 idle after drop", cfg_done, 1);
    endtask

    initial begin
        t_reset();
        t_sequence(2'd0, 0);
        t_sequence(2'd2, 1);
        t_sequence(2'd3, 0);
        t_sequence(2'd1, 1);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule